// File: doc/BRIEF.md
# Application State Selector

This block keeps the number of the application state a product is in, from 0 to 6, and moves it in response to user controls. Two sources can request a move. One is a pair of already debounced push-button pulses that step the state up or down. The other is a 4-bit rotary dial whose position is only taken when a separate commit pulse arrives. A mode input picks which of the two sources is listened to. The other source is ignored.

State 0 is a power-on setup state. The selector leaves it on its own one cycle after reset is released, always goes to state 1, and never returns to it. After that the state holds until a valid change request arrives. Every real move is marked by a one-cycle strobe, which the surrounding logic can use to start the work belonging to the new state. Dial positions outside the range 1 to 6 all land on state 6, the deepest sleep state.

Top module: `state_selector`

## Requirements
- R1: While `rst` is high at a clock edge, `state_o` becomes 0 and `change_o` becomes 0.
- R2: At the first clock edge after `rst` is released, `state_o` goes from 0 to 1 and `change_o` is 1 for that cycle, whatever the button, dial and commit inputs are.
- R3: Once `state_o` has left 0, no sequence of inputs short of reset brings it back to 0.
- R4: With `mode_dial` = 0, a cycle with `btn_up` high and `btn_down` low raises the state by one, and a cycle with `btn_down` high and `btn_up` low lowers it by one. The new value appears after the next clock edge.
- R5: In button mode, `btn_up` in state 6 leaves the state at 6, and `btn_down` in state 1 leaves it at 1. Neither raises `change_o`.
- R6: In button mode, a cycle with both `btn_up` and `btn_down` high leaves the state unchanged.
- R7: With `mode_dial` = 1, the state changes only in a cycle where `dial_commit` is high. A dial code of 1 to 6 then selects the state of the same number.
- R8: On a commit, dial codes 0 and 7 through 15 all select state 6.
- R9: In button mode, `dial_commit` has no effect. In dial mode, `btn_up` and `btn_down` have no effect.
- R10: `change_o` is high for exactly the cycle after an edge that gave `state_o` a new value. It stays low when a request selects the state already held, and `state_o` holds between requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dial | input | 1 | 0: button pair steps the state; 1: dial and commit select it |
| btn_up | input | 1 | One-cycle step-up pulse |
| btn_down | input | 1 | One-cycle step-down pulse |
| dial_code | input | 4 | Rotary dial position |
| dial_commit | input | 1 | One-cycle pulse that applies the dial position |
| state_o | output | 3 | Current application state, 0 to 6 |
| change_o | output | 1 | One-cycle strobe marking a new state |

## Verification
The bench runs into both saturation edges, repeating the step past 6 and past 1. A design that wraps would jump to 7 or 0, and one that does not saturate cleanly would raise a false strobe. It presses both buttons together and moves each source while the other mode is selected, which shows a design that lets one button win or that leaks the inactive path. It walks every out-of-range dial code and code 0 through a commit, with a different legal code committed between them so each one has to produce a visible move to 6. A decoder that passes 0 through or truncates 7 to 7 would expose state 0 or an illegal state. It also holds a button pulse in the cycle just after reset, where a design that honours the input would skip state 1.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int ST_W   = 3;
  localparam int CODE_W = 4;

  typedef enum logic {
    SRC_BUTTONS = 1'b0,
    SRC_DIAL    = 1'b1
  } src_e;
endpackage

// File: rtl/button_stepper.sv
module button_stepper #(
  parameter int ST_W = 3,
  parameter int LO   = 1,
  parameter int HI   = 6
) (
  input  logic [ST_W-1:0] cur,
  input  logic            up,
  input  logic            down,
  output logic            move,
  output logic [ST_W-1:0] target
);
  localparam logic [ST_W-1:0] LO_V = ST_W'(LO);
  localparam logic [ST_W-1:0] HI_V = ST_W'(HI);

  always_comb begin
    move   = 1'b0;
    target = cur;
    if (up && !down && cur < HI_V) begin
      move   = 1'b1;
      target = cur + 1'b1;
    end else if (down && !up && cur > LO_V) begin
      move   = 1'b1;
      target = cur - 1'b1;
    end
  end
endmodule

// File: rtl/dial_decoder.sv
module dial_decoder #(
  parameter int CODE_W   = 4,
  parameter int ST_W     = 3,
  parameter int LO       = 1,
  parameter int HI       = 6,
  parameter int FALLBACK = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [ST_W-1:0]   target
);
  localparam logic [CODE_W-1:0] LO_C = CODE_W'(LO);
  localparam logic [CODE_W-1:0] HI_C = CODE_W'(HI);

  always_comb begin
    if (code >= LO_C && code <= HI_C) target = ST_W'(code);
    else                              target = ST_W'(FALLBACK);
  end
endmodule

// File: rtl/state_selector.sv
module state_selector #(
  parameter int ST_W    = sel_pkg::ST_W,
  parameter int CODE_W  = sel_pkg::CODE_W,
  parameter int INIT_ST = 0,
  parameter int RUN_ST  = 1,
  parameter int TOP_ST  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dial,
  input  logic              btn_up,
  input  logic              btn_down,
  input  logic [CODE_W-1:0] dial_code,
  input  logic              dial_commit,
  output logic [ST_W-1:0]   state_o,
  output logic              change_o
);
  import sel_pkg::*;

  localparam logic [ST_W-1:0] INIT_V = ST_W'(INIT_ST);
  localparam logic [ST_W-1:0] RUN_V  = ST_W'(RUN_ST);
  localparam logic [ST_W-1:0] TOP_V  = ST_W'(TOP_ST);

  logic [ST_W-1:0] state_q, next_st, btn_target, dial_target;
  logic            change_q, btn_move;
  src_e            src;

  assign src = src_e'(mode_dial);

  button_stepper #(.ST_W(ST_W), .LO(RUN_ST), .HI(TOP_ST)) u_step (
    .cur(state_q), .up(btn_up), .down(btn_down),
    .move(btn_move), .target(btn_target)
  );

  dial_decoder #(.CODE_W(CODE_W), .ST_W(ST_W), .LO(RUN_ST), .HI(TOP_ST),
                 .FALLBACK(TOP_ST)) u_dial (
    .code(dial_code), .target(dial_target)
  );

  always_comb begin
    next_st = state_q;
    if (state_q == INIT_V)                        next_st = RUN_V;
    else if (src == SRC_BUTTONS && btn_move)      next_st = btn_target;
    else if (src == SRC_DIAL && dial_commit)      next_st = dial_target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= INIT_V;
      change_q <= 1'b0;
    end else begin
      state_q  <= next_st;
      change_q <= (next_st != state_q);
    end
  end

  assign state_o  = state_q;
  assign change_o = change_q;

  p_init_exit_r2: assert property (@(posedge clk) disable iff (rst)
    state_o == INIT_V |=> (state_o == RUN_V && change_o));

  p_no_reentry_r3: assert property (@(posedge clk) disable iff (rst)
    state_o != INIT_V |=> state_o != INIT_V);

  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_dial && state_o == TOP_V && btn_up && !btn_down) |=> state_o == TOP_V);

  p_sat_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_dial && state_o == RUN_V && btn_down && !btn_up) |=> state_o == RUN_V);

  p_both_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_dial && btn_up && btn_down && state_o != INIT_V) |=> $stable(state_o));

  p_dial_needs_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_dial && !dial_commit && state_o != INIT_V) |=> $stable(state_o));

  p_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    state_o <= TOP_V);

  p_strobe_means_move_r10: assert property (@(posedge clk) disable iff (rst)
    change_o |-> state_o != $past(state_o));
endmodule

// File: tb/tb_state_selector.sv
module tb_state_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_dial = 1'b0;
  logic       btn_up = 1'b0;
  logic       btn_down = 1'b0;
  logic [3:0] dial_code = 4'd0;
  logic       dial_commit = 1'b0;
  logic [2:0] state_o;
  logic       change_o;

  int    checks = 0;
  int    errors = 0;
  int    m_st = 0;
  int    m_chg = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  state_selector dut (
    .clk(clk), .rst(rst), .mode_dial(mode_dial), .btn_up(btn_up),
    .btn_down(btn_down), .dial_code(dial_code), .dial_commit(dial_commit),
    .state_o(state_o), .change_o(change_o)
  );

  // Behavioural reference, stepped at every edge from the sampled inputs.
  always @(posedge clk) begin
    int nxt;
    if (rst) begin
      m_st = 0; m_chg = 0;
    end else begin
      nxt = m_st;
      if (m_st == 0) nxt = 1;
      else if (!mode_dial) begin
        if (btn_up && !btn_down)      nxt = (m_st >= 6) ? 6 : m_st + 1;
        else if (btn_down && !btn_up) nxt = (m_st <= 1) ? 1 : m_st - 1;
      end else if (dial_commit) begin
        nxt = (dial_code >= 1 && dial_code <= 6) ? int'(dial_code) : 6;
      end
      m_chg = (nxt != m_st) ? 1 : 0;
      m_st  = nxt;
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (int'(state_o) != m_st || int'(change_o) != m_chg) begin
        errors++;
        $display("FAIL %s: state=%0d change=%0d expected state=%0d change=%0d",
                 tag, state_o, change_o, m_st, m_chg);
      end
      if (!rst && m_st != 0 && state_o == 3'd0) begin
        errors++;
        $display("FAIL R3: state=0 expected nonzero");
      end
    end
  end

  task automatic cyc(input bit up, input bit dn, input bit cm, input logic [3:0] code);
    @(negedge clk);
    btn_up = up; btn_down = dn; dial_commit = cm; dial_code = code;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, dial_code);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R2";
    btn_up = 1'b1;            // first cycle after reset: must be ignored
    cyc(0, 0, 0, 0);
    idle(2);
    tag = "R4";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    idle(1);
    tag = "R5";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0);
    tag = "R6";
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    idle(1);
    tag = "R9";
    cyc(0, 0, 1, 4'd5);
    idle(1);
    mode_dial = 1'b1;
    cyc(1, 0, 0, 4'd5);
    cyc(0, 1, 0, 4'd5);
    idle(1);
    tag = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 4'd3);
    cyc(0, 0, 1, 4'd3);
    idle(1);
    tag = "R10";
    cyc(0, 0, 1, 4'd3);
    idle(2);
    tag = "R7";
    for (int c = 1; c <= 6; c++) begin
      cyc(0, 0, 1, 4'(c));
      idle(1);
    end
    tag = "R8";
    for (int c = 0; c <= 15; c++) begin
      if (c == 0 || c >= 7) begin
        cyc(0, 0, 1, 4'd2);
        cyc(0, 0, 1, 4'(c));
        idle(1);
      end
    end
    tag = "R3";
    mode_dial = 1'b0;
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0);
    mode_dial = 1'b1;
    cyc(0, 0, 1, 4'd0);
    idle(2);
    tag = "R1";
    @(negedge clk); rst = 1'b1;
    cyc(1, 0, 1, 4'd4);
    idle(1);
    rst = 1'b0;
    tag = "R2";
    idle(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule